// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a multicycle processor that shares one memory between instruction and data accesses and one ALU between address, branch-target and data arithmetic. It holds a 4-bit state register and, from that state, drives every select and write enable of the surrounding datapath. Each instruction takes a fixed path of states. Every path starts with a common fetch and a common decode, and every path ends by returning to fetch.

Five instruction classes are recognised by the 6-bit opcode. Three of them run through the ALU: register-register, OR with an immediate, and branch-if-equal. The other two are load word and store word. During decode, the sequencer already has the ALU form the branch target, PC plus the sign-extended immediate shifted left by two. The branch state then only compares the two operands and loads the PC on zero. An opcode outside the five classes returns to fetch. The controls are a pure function of the state, apart from the combined PC load enable, which also depends on the zero flag.

Top module: `mcc_controller`

## Requirements
- R1: Reset is synchronous and active high. In the first cycle after reset is released, the outputs carry the fetch controls (state 0000).
- R2: The fetch state (0000) drives these controls: `mem_rd`=1, `addr_sel`=0 (address from PC), `ir_wr`=1, `alu_src_a`=0 (PC), `alu_src_b`=00 (constant 4), `alu_op`=00 (add), `pc_wr`=1 and `pc_src`=0 (ALU result). Decode always follows fetch.
- R3: The decode state (0001) drives `alu_src_a`=0, `alu_src_b`=10 (extended immediate shifted left 2), `ext_sign`=1 and `alu_op`=00. The next state depends on the opcode: 000000 goes to 0100, 001101 to 0110, 100011 to 1000, 101011 to 1011 and 000100 to 0010.
- R4: The register-register path has two states. State 0100 drives `alu_src_a`=1, `alu_src_b`=01 (register rt) and `alu_op`=10 (function code). State 0101 then drives `reg_wr`=1, `reg_dst`=1 (rd) and `mem_to_reg`=0. The sequencer then returns to fetch.
- R5: The OR-immediate path has two states. State 0110 drives `alu_src_a`=1, `alu_src_b`=11 (extended immediate), `ext_sign`=0 and `alu_op`=11 (OR). State 0111 then drives `reg_wr`=1, `reg_dst`=0 (rt) and `mem_to_reg`=0. The sequencer then returns to fetch.
- R6: The load path has three states. State 1000 drives `alu_src_a`=1, `alu_src_b`=11, `ext_sign`=1 and `alu_op`=00. State 1001 drives `mem_rd`=1 and `addr_sel`=1 (address from ALUout). State 1010 drives `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0. The sequencer then returns to fetch.
- R7: The store path has two states. State 1011 drives the same controls as state 1000. State 1100 drives `mem_wr`=1 and `addr_sel`=1. The sequencer then returns to fetch.
- R8: The branch state (0010) drives `alu_src_a`=1, `alu_src_b`=01, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=1 (ALUout). `pc_en` equals `pc_wr` OR (`pc_wr_cond` AND `alu_zero`). The sequencer then returns to fetch.
- R9: If decode sees an opcode outside the five listed, the next state is fetch.
- R10: Every control output that a state does not name above is 0 in that state. In particular, `mem_rd` and `mem_wr` are never 1 together, and `pc_en` is 1 only in fetch, or in the branch state with `alu_zero`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by zero |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUout |
| pc_en | output | 1 | Combined PC load enable |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUout |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALUout, 1 memory data |
| alu_src_a | output | 1 | First ALU operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | Second ALU operand select |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 function, 11 OR |

## Verification
The bench goes after the dispatch corners. Illegal opcodes are presented at decode: a sequencer that falls through to some execute state there would drive a register or memory write that nothing asked for. Opcodes also change in every cycle outside decode, which catches a design that samples the opcode outside decode and leaves its path early. The branch state is driven with both zero values, which exposes a PC load enable that ignores the flag or that leaks the conditional write into other states. A reset applied in the middle of a path checks that the sequencer really returns to fetch and does not finish the instruction it was running.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPW = 6;
  localparam int STW = 4;

  typedef enum logic [STW-1:0] {
    ST_FETCH  = 4'b0000,
    ST_DECODE = 4'b0001,
    ST_BEQ    = 4'b0010,
    ST_RX     = 4'b0100,
    ST_RWB    = 4'b0101,
    ST_OX     = 4'b0110,
    ST_OWB    = 4'b0111,
    ST_LA     = 4'b1000,
    ST_LM     = 4'b1001,
    ST_LWB    = 4'b1010,
    ST_SA     = 4'b1011,
    ST_SM     = 4'b1100
  } state_e;

  localparam logic [OPW-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPW-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPW-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OPW-1:0] OPC_LW    = 6'b100011;
  localparam logic [OPW-1:0] OPC_SW    = 6'b101011;

  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;
  localparam logic [1:0] AOP_OR   = 2'b11;

  localparam logic [1:0] SB_FOUR = 2'b00;
  localparam logic [1:0] SB_RT   = 2'b01;
  localparam logic [1:0] SB_IMSH = 2'b10;
  localparam logic [1:0] SB_IMM  = 2'b11;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       pc_src;
    logic       mem_rd;
    logic       mem_wr;
    logic       addr_sel;
    logic       ir_wr;
    logic       reg_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic       ext_sign;
    logic [1:0] alu_op;
  } ctrl_t;

  // Dispatch target for an opcode seen in decode; unknown codes go to fetch.
  function automatic state_e dispatch(input logic [OPW-1:0] op);
    case (op)
      OPC_RTYPE: return ST_RX;
      OPC_ORI:   return ST_OX;
      OPC_LW:    return ST_LA;
      OPC_SW:    return ST_SA;
      OPC_BEQ:   return ST_BEQ;
      default:   return ST_FETCH;
    endcase
  endfunction

  // PC load rule: unconditional write, or conditional write gated by zero.
  function automatic logic pc_load(input logic wr, input logic wr_cond, input logic zero);
    return wr | (wr_cond & zero);
  endfunction

endpackage

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  state_e         cur,
  input  logic [OPW-1:0] opcode,
  output state_e         nxt,
  output logic           in_dispatch
);

  assign in_dispatch = (cur == ST_DECODE);

  always_comb begin
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = dispatch(opcode);
      ST_RX:     nxt = ST_RWB;
      ST_OX:     nxt = ST_OWB;
      ST_LA:     nxt = ST_LM;
      ST_LM:     nxt = ST_LWB;
      ST_SA:     nxt = ST_SM;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.alu_src_b = SB_FOUR;
        ctl.alu_op    = AOP_ADD;
        ctl.pc_wr     = 1'b1;
      end
      ST_DECODE: begin
        ctl.alu_src_b = SB_IMSH;
        ctl.ext_sign  = 1'b1;
        ctl.alu_op    = AOP_ADD;
      end
      ST_BEQ: begin
        ctl.alu_src_a  = 1'b1;
        ctl.alu_src_b  = SB_RT;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = 1'b1;
      end
      ST_RX: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SB_RT;
        ctl.alu_op    = AOP_FUNC;
      end
      ST_RWB: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      ST_OX: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SB_IMM;
        ctl.alu_op    = AOP_OR;
      end
      ST_OWB: ctl.reg_wr = 1'b1;
      ST_LA, ST_SA: begin
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = SB_IMM;
        ctl.ext_sign  = 1'b1;
        ctl.alu_op    = AOP_ADD;
      end
      ST_LM: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LWB: begin
        ctl.reg_wr     = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      ST_SM: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcc_controller.sv
module mcc_controller
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic       alu_zero,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       pc_src,
  output logic       pc_en,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       addr_sel,
  output logic       ir_wr,
  output logic       reg_wr,
  output logic       reg_dst,
  output logic       mem_to_reg,
  output logic       alu_src_a,
  output logic [1:0] alu_src_b,
  output logic       ext_sign,
  output logic [1:0] alu_op
);

  state_e st_q;
  state_e st_d;
  logic   in_dispatch;
  ctrl_t  ctl;

  mcc_next_state u_next (
    .cur         (st_q),
    .opcode      (opcode),
    .nxt         (st_d),
    .in_dispatch (in_dispatch)
  );

  mcc_ctrl_decode u_dec (
    .cur (st_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH;
    else     st_q <= st_d;
  end

  assign pc_wr      = ctl.pc_wr;
  assign pc_wr_cond = ctl.pc_wr_cond;
  assign pc_src     = ctl.pc_src;
  assign mem_rd     = ctl.mem_rd;
  assign mem_wr     = ctl.mem_wr;
  assign addr_sel   = ctl.addr_sel;
  assign ir_wr      = ctl.ir_wr;
  assign reg_wr     = ctl.reg_wr;
  assign reg_dst    = ctl.reg_dst;
  assign mem_to_reg = ctl.mem_to_reg;
  assign alu_src_a  = ctl.alu_src_a;
  assign alu_src_b  = ctl.alu_src_b;
  assign ext_sign   = ctl.ext_sign;
  assign alu_op     = ctl.alu_op;
  assign pc_en      = pc_load(ctl.pc_wr, ctl.pc_wr_cond, alu_zero);

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_wr && mem_rd && pc_wr)); // R1
  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (in_dispatch && alu_src_b == SB_IMSH && !reg_wr && !mem_wr)); // R3
  AST_RTYPE_WB: assert property (@(posedge clk) disable iff (rst)
    (alu_op == AOP_FUNC) |=> (reg_wr && reg_dst && !mem_to_reg)); // R4
  AST_LOAD_WB: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (reg_wr && mem_to_reg)); // R6
  AST_STORE_RET: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr); // R7
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond && !alu_zero) |-> !pc_en); // R8
  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R10
  AST_PC_EN_SCOPE: assert property (@(posedge clk) disable iff (rst)
    pc_en |-> (ir_wr || (pc_wr_cond && alu_zero))); // R10

endmodule

// File: tb/mcc_controller_tb.sv
module mcc_controller_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       alu_zero = 1'b0;
  logic       pc_wr, pc_wr_cond, pc_src, pc_en, mem_rd, mem_wr, addr_sel, ir_wr;
  logic       reg_wr, reg_dst, mem_to_reg, alu_src_a, ext_sign;
  logic [1:0] alu_src_b, alu_op;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mcc_controller u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .pc_en(pc_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
    .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .ext_sign(ext_sign),
    .alu_op(alu_op)
  );

  // Vector layout: pc_wr pc_wr_cond pc_src pc_en mem_rd mem_wr addr_sel ir_wr
  //                reg_wr reg_dst mem_to_reg alu_src_a alu_src_b[2] ext_sign alu_op[2]
  function automatic logic [16:0] mk(input logic pw, pwc, ps, pe, mr, mw, asel, iw,
                                     rw, rd, m2r, sa, input logic [1:0] sb,
                                     input logic ex, input logic [1:0] op);
    return {pw, pwc, ps, pe, mr, mw, asel, iw, rw, rd, m2r, sa, sb, ex, op};
  endfunction

  // Expected outputs from the requirements, per state (R10: unnamed = 0).
  function automatic logic [16:0] expect_vec(input logic [3:0] s, input logic z);
    case (s)
      4'd0:  return mk(1,0,0,1, 1,0,0,1, 0,0,0,0, 2'b00, 0, 2'b00);
      4'd1:  return mk(0,0,0,0, 0,0,0,0, 0,0,0,0, 2'b10, 1, 2'b00);
      4'd2:  return mk(0,1,1,z, 0,0,0,0, 0,0,0,1, 2'b01, 0, 2'b01);
      4'd4:  return mk(0,0,0,0, 0,0,0,0, 0,0,0,1, 2'b01, 0, 2'b10);
      4'd5:  return mk(0,0,0,0, 0,0,0,0, 1,1,0,0, 2'b00, 0, 2'b00);
      4'd6:  return mk(0,0,0,0, 0,0,0,0, 0,0,0,1, 2'b11, 0, 2'b11);
      4'd7:  return mk(0,0,0,0, 0,0,0,0, 1,0,0,0, 2'b00, 0, 2'b00);
      4'd8, 4'd11:
             return mk(0,0,0,0, 0,0,0,0, 0,0,0,1, 2'b11, 1, 2'b00);
      4'd9:  return mk(0,0,0,0, 1,0,1,0, 0,0,0,0, 2'b00, 0, 2'b00);
      4'd10: return mk(0,0,0,0, 0,0,0,0, 1,0,1,0, 2'b00, 0, 2'b00);
      4'd12: return mk(0,0,0,0, 0,1,1,0, 0,0,0,0, 2'b00, 0, 2'b00);
      default: return '0;
    endcase
  endfunction

  function automatic logic [3:0] expect_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == 6'b000000) return 4'd4;
        if (op == 6'b001101) return 4'd6;
        if (op == 6'b100011) return 4'd8;
        if (op == 6'b101011) return 4'd11;
        if (op == 6'b000100) return 4'd2;
        return 4'd0;
      end
      4'd4: return 4'd5;
      4'd6: return 4'd7;
      4'd8: return 4'd9;
      4'd9: return 4'd10;
      4'd11: return 4'd12;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2+R10";
      4'd1: return "R3+R10";
      4'd2: return "R8+R10";
      4'd4, 4'd5: return "R4+R10";
      4'd6, 4'd7: return "R5+R10";
      4'd8, 4'd9, 4'd10: return "R6+R10";
      default: return "R7+R10";
    endcase
  endfunction

  function automatic logic [5:0] pick_op(input int k);
    case (k)
      0: return 6'b000000;
      1: return 6'b001101;
      2: return 6'b100011;
      3: return 6'b101011;
      4: return 6'b000100;
      5: return 6'b000010;
      6: return 6'b111111;
      default: return 6'($urandom);
    endcase
  endfunction

  function automatic logic [16:0] actual();
    return {pc_wr, pc_wr_cond, pc_src, pc_en, mem_rd, mem_wr, addr_sel, ir_wr,
            reg_wr, reg_dst, mem_to_reg, alu_src_a, alu_src_b, ext_sign, alu_op};
  endfunction

  task automatic check(input string tag, input logic [16:0] exp_v);
    n_vec++;
    if (actual() !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, actual(), exp_v);
    end
  endtask

  logic [3:0] est = 4'd0;
  logic       illegal_seen = 1'b0;

  // One cycle: drive at negedge, compare, advance the model.
  task automatic step(input logic [5:0] op, input logic z);
    @(negedge clk);
    opcode   = op;
    alu_zero = z;
    #1;
    if (illegal_seen) check("R9", expect_vec(est, z));
    else              check(tag_of(est), expect_vec(est, z));
    illegal_seen = (est == 4'd1) && (expect_next(est, op) == 4'd0);
    est = expect_next(est, op);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", expect_vec(4'd0, 1'b0));   // reset state is fetch
    est = 4'd1;

    // Directed: each legal opcode, branch with both zero values, illegal codes (R9).
    step(6'b101011, 1'b0);                 // decode -> store
    step(6'b111111, 1'b1);
    step(6'b111111, 1'b1);
    step(6'b000000, 1'b0);                 // fetch
    step(6'b000100, 1'b0);                 // decode -> branch
    step(6'b000000, 1'b0);                 // branch, zero=0 (R8)
    step(6'b000000, 1'b0);
    step(6'b000100, 1'b1);
    step(6'b000000, 1'b1);                 // branch, zero=1 (R8)
    step(6'b000000, 1'b0);
    step(6'b000010, 1'b0);                 // illegal at decode (R9)
    step(6'b000000, 1'b0);

    // Constrained random.
    for (int i = 0; i < 3000; i++) begin
      step(pick_op(int'($urandom_range(0, 7))), 1'($urandom));
      if (i == 1500) begin
        // Mid-path reset: next cycle must be fetch (R1).
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", expect_vec(4'd0, alu_zero));
        est = 4'd1;
        illegal_seen = 1'b0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule